// File: doc/BRIEF.md
# Adaptive Rice Block Coder

This block turns a stream of prediction residuals into a packed, variable-length bit stream. Each residual arrives with the prediction it was formed against. The prediction bounds the range of the residual, and a mapper uses that bound to fold the signed residual into a non-negative value. Mapped values are gathered into blocks of up to J samples. For each block the coder works out how many bits every coding option would need, picks the cheapest, and emits a short option identifier followed by the block's codes.

At the first block of every reference interval, the original pixel value of that block's first sample is sent raw, right after the identifier. That sample is left out of the coded data. The interval length, counted in blocks, can be reloaded at run time. Bits are packed most significant first into bytes on a valid/ready output stream. The final sample of an image is flagged on the input. It closes its block, even a partial one. The coder then pads the last byte with zeros, and raises `done` once that byte has been taken.

Both data edges are valid/ready streams. The input is stalled, with `s_ready` low, from the acceptance of a block's last sample until the whole block has been serialised. The output holds `m_data` steady while `m_valid` is high and `m_ready` is low. The coder never drops or reorders a byte under back-pressure.

Top module: `rice_block_coder`

## Requirements
- R1: With theta = min(pred, 255 - pred) and residual d, the mapped value is 2d when 0 <= d <= theta, 2|d|-1 when -theta <= d < 0, and theta+|d| otherwise.
- R2: Every block starts with a 3-bit option ID sent MSB first. Output bits are packed MSB first into bytes. A block closes after J = 16 accepted samples or at the sample flagged `s_last`.
- R3: The option IDs and their codes are fixed as follows. ID 0 sends nothing more. ID k+1, for k from 0 to 5, sends each mapped value m as floor(m/2^k) zeros, then a one, then the k low bits of m MSB first. ID 7 sends each mapped value as 8 raw bits, MSB first.
- R4: The chosen ID has the fewest code bits among the options. On a tie, the lowest ID wins. ID 0 is used exactly when every coded mapped value is zero, or when no sample is coded.
- R5: In the first block after reset, and in the first block of every reference interval, the first sample's pixel value (pred + d) follows the ID as 8 raw bits. That sample is not mapped or coded.
- R6: The interval length in blocks is 32 after reset. A pulse on `cfg_load` replaces it with `cfg_ref_blocks`, and the new value applies from the next block boundary. A value of 0 acts as 1.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` does not change.
- R8: After accepting the 16th sample of a block, `s_ready` is low until that block has been fully emitted.
- R9: After the `s_last` block, the last byte is padded with zero bits. `done` rises after that byte is taken and then stays high, with `s_ready` and `m_valid` low.
- R10: Just after reset, `m_valid` and `done` are low and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load strobe for the reference interval |
| cfg_ref_blocks | input | 8 | New reference interval in blocks |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted when high with s_valid |
| s_resid | input | 9 | Signed prediction residual |
| s_pred | input | 8 | Prediction the residual refers to |
| s_last | input | 1 | Marks the final sample of the image |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Output byte taken when high with m_valid |
| m_data | output | 8 | Packed code byte |
| done | output | 1 | All bytes of the image have been delivered |

## Verification
Blocks of exact predictions must select ID 0. Small symmetric residuals favour low split values, and moderate residuals around mid-scale favour higher ones, so these blocks separate the length comparison from the tie rule. Predictions close to 0 and 255 with far-off pixels drive the mapper into its beyond-theta branch and push selection to raw coding. Interval lengths of 32, 2 and 0 change which blocks carry a raw reference. A final block holding only a reference sample, and a short partial block, exercise the close-and-pad path while output readiness is throttled.

// File: rtl/rice_pkg.sv
package rice_pkg;
  typedef enum logic [2:0] {
    ST_COLL, ST_ID, ST_REF, ST_SAMP, ST_NEXT, ST_PAD, ST_WAIT, ST_DONE
  } rice_state_t;
endpackage

// File: rtl/rice_map.sv
module rice_map #(
  parameter int N = 8
) (
  input  logic signed [N:0] resid,
  input  logic [N-1:0]      pred,
  output logic [N-1:0]      mapped,
  output logic [N-1:0]      pixel
);
  localparam logic [N-1:0] MAXV = {N{1'b1}};

  logic [N-1:0] theta;
  logic [N:0]   mag;
  logic [N+1:0] wide;

  always_comb begin
    theta = (pred < (MAXV - pred)) ? pred : (MAXV - pred);
    mag   = resid[N] ? (N+1)'(-resid) : resid;
    if (mag <= {1'b0, theta})
      wide = resid[N] ? (({1'b0, mag} << 1) - 1'b1) : ({1'b0, mag} << 1);
    else
      wide = (N+2)'(theta) + (N+2)'(mag);
    mapped = wide[N-1:0];
    pixel  = pred + resid[N-1:0];
  end
endmodule

// File: rtl/rice_pick.sv
module rice_pick #(
  parameter int N    = 8,
  parameter int KMAX = 5,
  parameter int CW   = 5,
  parameter int SW   = 13,
  parameter int ID_W = 3
) (
  input  logic [KMAX:0][SW-1:0] sums,
  input  logic [CW-1:0]         ncode,
  input  logic                  anynz,
  output logic [ID_W-1:0]       opt
);
  localparam int LW = SW + 4;

  logic [LW-1:0] best;
  logic [LW-1:0] cand;

  always_comb begin
    best = LW'(ncode) * LW'(N);
    opt  = {ID_W{1'b1}};
    cand = '0;
    for (int k = KMAX; k >= 0; k--) begin
      cand = LW'(ncode) * LW'(k + 1) + LW'(sums[k]);
      if (cand <= best) begin
        best = cand;
        opt  = ID_W'(k + 1);
      end
    end
    if (!anynz) opt = '0;
  end
endmodule

// File: rtl/rice_pack.sv
module rice_pack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_vld,
  input  logic       bit_val,
  output logic       bit_rdy,
  output logic [2:0] fill,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data
);
  logic [6:0] acc;
  logic       take;

  assign bit_rdy = !((fill == 3'd7) && m_valid && !m_ready);
  assign take    = bit_vld && bit_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      fill    <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      if (take && fill == 3'd7) begin
        m_data  <= {acc, bit_val};
        m_valid <= 1'b1;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
      if (take) begin
        acc  <= {acc[5:0], bit_val};
        fill <= fill + 3'd1;
      end
    end
  end
endmodule

// File: rtl/rice_block_coder.sv
module rice_block_coder
  import rice_pkg::*;
#(
  parameter int N       = 8,
  parameter int J       = 16,
  parameter int KMAX    = 5,
  parameter int RW      = 8,
  parameter int REF_DEF = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [RW-1:0]     cfg_ref_blocks,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic signed [N:0] s_resid,
  input  logic [N-1:0]      s_pred,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [7:0]        m_data,
  output logic              done
);
  localparam int IW   = $clog2(J);
  localparam int CW   = $clog2(J + 1);
  localparam int SW   = N + CW;
  localparam int ID_W = $clog2(KMAX + 3);
  localparam int LCW  = $clog2(N);
  localparam int CNW  = $clog2(N + ID_W);
  localparam logic [ID_W-1:0] NOCOMP = {ID_W{1'b1}};

  rice_state_t st;
  logic [N-1:0]   mbuf [J];
  logic [IW-1:0]  idx, si;
  logic [CW-1:0]  ncode, nsamp;
  logic           anynz, is_ref, last_blk;
  logic [N-1:0]   ref_val, qc;
  logic [RW-1:0]  bcnt, lim;
  logic [CNW-1:0] cnt;
  logic [LCW-1:0] lc;
  logic           ph;

  logic [N-1:0]   mapped, pixel, cur, qv;
  logic [ID_W-1:0] opt, kk;
  logic [KMAX:0][SW-1:0] sums;
  logic           hs_in, first, close, clr, take_code;
  logic           bit_vld, bit_val, bit_rdy, adv, nocomp;
  logic [2:0]     fill;
  logic           start_ph;
  logic [LCW-1:0] start_lc;

  rice_map #(.N(N)) u_map (
    .resid(s_resid), .pred(s_pred), .mapped(mapped), .pixel(pixel)
  );

  assign s_ready   = (st == ST_COLL);
  assign hs_in     = s_valid && s_ready;
  assign first     = (idx == '0) && (bcnt == '0);
  assign close     = hs_in && ((idx == IW'(J - 1)) || s_last);
  assign take_code = hs_in && !first;
  assign clr       = (st == ST_NEXT) && !last_blk;
  assign done      = (st == ST_DONE);

  for (genvar gk = 0; gk <= KMAX; gk++) begin : g_sum
    logic [SW-1:0] acc;
    always_ff @(posedge clk) begin
      if (!rst_n || clr) acc <= '0;
      else if (take_code) acc <= acc + SW'(mapped >> gk);
    end
    assign sums[gk] = acc;
  end

  rice_pick #(.N(N), .KMAX(KMAX), .CW(CW), .SW(SW), .ID_W(ID_W)) u_pick (
    .sums(sums), .ncode(ncode), .anynz(anynz), .opt(opt)
  );

  assign nocomp   = (opt == NOCOMP);
  assign kk       = opt - 1'b1;
  assign cur      = mbuf[si];
  assign qv       = cur >> kk;
  assign start_ph = nocomp;
  assign start_lc = nocomp ? LCW'(N - 1) : LCW'(kk - 1'b1);

  always_comb begin
    bit_vld = 1'b0;
    bit_val = 1'b0;
    case (st)
      ST_ID:   begin bit_vld = 1'b1; bit_val = opt[ID_W-1-int'(cnt)]; end
      ST_REF:  begin bit_vld = 1'b1; bit_val = ref_val[N-1-int'(cnt)]; end
      ST_SAMP: begin bit_vld = 1'b1; bit_val = ph ? cur[lc] : (qc == qv); end
      ST_PAD:  bit_vld = (fill != 3'd0);
      default: ;
    endcase
  end
  assign adv = bit_vld && bit_rdy;

  rice_pack u_pack (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .bit_rdy(bit_rdy), .fill(fill), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data)
  );

  always_ff @(posedge clk) begin
    if (hs_in && !first) mbuf[idx] <= mapped;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim <= RW'(REF_DEF);
    end else if (cfg_load) begin
      lim <= cfg_ref_blocks;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_COLL;
      idx <= '0; si <= '0; ncode <= '0; nsamp <= '0;
      anynz <= 1'b0; is_ref <= 1'b0; last_blk <= 1'b0;
      ref_val <= '0; qc <= '0; bcnt <= '0; cnt <= '0; lc <= '0; ph <= 1'b0;
    end else begin
      case (st)
        ST_COLL: if (hs_in) begin
          if (first) begin
            ref_val <= pixel;
            is_ref  <= 1'b1;
          end else begin
            ncode <= ncode + 1'b1;
            if (mapped != '0) anynz <= 1'b1;
          end
          idx <= idx + 1'b1;
          if (close) begin
            st       <= ST_ID;
            cnt      <= '0;
            last_blk <= s_last;
            nsamp    <= CW'(idx) + 1'b1;
          end
        end
        ST_ID: if (adv) begin
          if (cnt == CNW'(ID_W - 1)) begin
            cnt <= '0;
            if (is_ref) st <= ST_REF;
            else if (opt != '0) begin
              st <= ST_SAMP; si <= '0; ph <= start_ph; lc <= start_lc; qc <= '0;
            end else st <= ST_NEXT;
          end else cnt <= cnt + 1'b1;
        end
        ST_REF: if (adv) begin
          if (cnt == CNW'(N - 1)) begin
            cnt <= '0;
            if (opt != '0) begin
              st <= ST_SAMP; si <= IW'(1); ph <= start_ph; lc <= start_lc; qc <= '0;
            end else st <= ST_NEXT;
          end else cnt <= cnt + 1'b1;
        end
        ST_SAMP: if (adv) begin
          if (!ph && qc != qv) begin
            qc <= qc + 1'b1;
          end else if (!ph && kk != '0) begin
            ph <= 1'b1;
            lc <= LCW'(kk - 1'b1);
          end else if (ph && lc != '0) begin
            lc <= lc - 1'b1;
          end else if (CW'(si) + 1'b1 == nsamp) begin
            st <= ST_NEXT;
          end else begin
            si <= si + 1'b1; ph <= start_ph; lc <= start_lc; qc <= '0;
          end
        end
        ST_NEXT: begin
          bcnt <= (RW'(bcnt + 1'b1) >= lim) ? '0 : bcnt + 1'b1;
          if (last_blk) st <= ST_PAD;
          else begin
            st <= ST_COLL; idx <= '0; ncode <= '0; anynz <= 1'b0; is_ref <= 1'b0;
          end
        end
        ST_PAD:  if (fill == 3'd0) st <= ST_WAIT;
        ST_WAIT: if (!m_valid) st <= ST_DONE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rice_coder_chk.sv
module rice_coder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_valid,
  input logic       s_ready,
  input logic       s_last,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       done
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data)); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !s_ready && !m_valid); // R9

  AST_LAST_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && s_last |=> !s_ready); // R8
endmodule

bind rice_block_coder rice_coder_chk i_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .s_last(s_last), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .done(done)
);

// File: tb/test_rice_block_coder.sv
module test_rice_block_coder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [7:0] cfg_ref_blocks = '0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic signed [8:0] s_resid = '0;
  logic [7:0] s_pred = '0;
  logic s_last = 1'b0;
  logic m_valid;
  logic m_ready = 1'b0;
  logic [7:0] m_data;
  logic done;

  int checks = 0, fails = 0;
  int xs[$], ps[$];
  bit bits[$];
  int expq[$];
  logic [7:0] lfsr = 8'h5a;

  always #10 clk = ~clk;

  rice_block_coder i_rice_block_coder (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ref_blocks(cfg_ref_blocks),
    .s_valid(s_valid), .s_ready(s_ready), .s_resid(s_resid), .s_pred(s_pred),
    .s_last(s_last), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R1 mapping rule
  function automatic int map_res(input int x, input int p);
    int th, d;
    th = (p < 255 - p) ? p : 255 - p;
    d = x - p;
    if (d >= 0 && d <= th) return 2 * d;
    if (d < 0 && -d <= th) return -2 * d - 1;
    return th + ((d < 0) ? -d : d);
  endfunction

  task automatic push_bits(input int v, input int w);
    for (int b = w - 1; b >= 0; b--) bits.push_back(bit'((v >> b) & 1));
  endtask

  // Expected stream built from R2..R6 and R9
  task automatic model(input int lim);
    int i, bc;
    bits.delete();
    expq.delete();
    i = 0; bc = 0;
    while (i < xs.size()) begin
      int n, ms[$], id, best, len;
      bit isref, nz;
      n = (xs.size() - i < 16) ? xs.size() - i : 16;
      isref = (bc == 0);
      nz = 0;
      for (int j = (isref ? 1 : 0); j < n; j++) begin
        ms.push_back(map_res(xs[i + j], ps[i + j]));
        if (ms[$] != 0) nz = 1;
      end
      best = ms.size() * 8; id = 7;
      for (int k = 5; k >= 0; k--) begin
        len = ms.size() * (k + 1);
        foreach (ms[q]) len += ms[q] >> k;
        if (len <= best) begin best = len; id = k + 1; end
      end
      if (!nz) id = 0;
      push_bits(id, 3);
      if (isref) push_bits(xs[i], 8);
      if (id != 0) foreach (ms[q]) begin
        if (id == 7) push_bits(ms[q], 8);
        else begin
          for (int z = 0; z < (ms[q] >> (id - 1)); z++) bits.push_back(1'b0);
          bits.push_back(1'b1);
          push_bits(ms[q], id - 1);
        end
      end
      i += n;
      bc = (bc + 1 >= lim) ? 0 : bc + 1;
    end
    while (bits.size() % 8 != 0) bits.push_back(1'b0);
    for (int b = 0; b < bits.size(); b += 8) begin
      int v;
      v = 0;
      for (int t = 0; t < 8; t++) v = (v << 1) | int'(bits[b + t]);
      expq.push_back(v);
    end
  endtask

  task automatic add_block(input int pat, input int cnt);
    for (int j = 0; j < cnt; j++) begin
      int p, x;
      case (pat)
        0: begin p = (j * 37) % 256; x = p; end
        1: begin p = 128; x = 128 + (j % 5) - 2; end
        2: begin p = (j % 2) ? 3 : 252; x = (j * 53) % 256; end
        3: begin p = (j * 29 + 7) % 256; x = (j * 101 + 5) % 256; end
        default: begin p = 100; x = 100 + ((j * 7) % 31) - 15; end
      endcase
      xs.push_back(x);
      ps.push_back(p);
    end
  endtask

  // Output side: throttled ready, byte compare on every accepted byte
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    m_ready = lfsr[0] | lfsr[2];
    if (rst_n && m_valid && m_ready) begin
      if (expq.size() == 0) chk(1'b0, "R2/R9 extra byte", int'(m_data), -1);
      else begin
        int e;
        e = expq.pop_front();
        chk(int'(m_data) == e, "R1/R2/R3/R4/R5 stream byte", int'(m_data), e);
      end
    end
  end

  task automatic send_all();
    for (int i = 0; i < xs.size(); i++) begin
      bit acc;
      if (i % 7 == 6) begin s_valid = 1'b0; @(negedge clk); end
      s_valid = 1'b1;
      s_resid = 9'(xs[i] - ps[i]);
      s_pred  = 8'(ps[i]);
      s_last  = (i == xs.size() - 1);
      acc = 1'b0;
      while (!acc) begin acc = s_ready; @(negedge clk); end
      if (i % 16 == 15 && i != xs.size() - 1)
        chk(s_ready == 1'b0, "R8 stall after full block", int'(s_ready), 0);
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic run(input bit do_load, input int lim);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_valid == 1'b0, "R10 m_valid after reset", int'(m_valid), 0);
    chk(done == 1'b0, "R10 done after reset", int'(done), 0);
    chk(s_ready == 1'b1, "R10 s_ready after reset", int'(s_ready), 1);
    if (do_load) begin
      cfg_ref_blocks = 8'(lim);
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
    end
    model(do_load ? lim : 32); // R6 default interval
    send_all();
    while (!done) @(negedge clk);
    chk(expq.size() == 0, "R9 all padded bytes delivered", expq.size(), 0);
    chk(s_ready == 1'b0, "R9 input closed when done", int'(s_ready), 0);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R9 done sticky", int'(done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // default interval: zero blocks, small, beyond-theta, wide, short tail
    xs.delete(); ps.delete();
    add_block(0, 16); add_block(0, 16); add_block(1, 16);
    add_block(2, 16); add_block(3, 16); add_block(4, 5);
    run(1'b0, 32);
    // R6 interval of 2 blocks; last block holds only a reference
    xs.delete(); ps.delete();
    add_block(4, 16); add_block(0, 16); add_block(1, 16); add_block(2, 16);
    add_block(3, 1);
    run(1'b1, 2);
    // R6 zero acts as one: every block carries a reference
    xs.delete(); ps.delete();
    add_block(1, 16); add_block(3, 16); add_block(4, 3);
    run(1'b1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule